// File: doc/BRIEF.md
# Dual 8-bit Compare Timer with 16-bit Cascade

This block contains two 8-bit up-counters. Each has its own control register, its own compare register and its own interrupt line. Each counter advances on a single-cycle strobe that its 3-bit source field picks from a bank of seven prescaled tick strobes. When a counter steps onto the value in its compare register, its match flag is set. Software clears the flag by writing a one to a clear bit. The interrupt line is high while the flag and the enable bit are both set.

When the all-ones source code is written into the second timer's control register, the two counters join into one 16-bit counter. The first counter is the low byte and the second is the high byte. The first timer's source field, start bit, flag and enable then govern the pair. The second timer's flag, start and interrupt take no further part.

Software uses a small register bus. Address 0 is control 0, address 1 is data 0, address 2 is control 1 and address 3 is data 1. A write to a data address loads the compare value. A read of a data address returns the live counter byte.

Top module: `dualCmpTimer`

## Requirements
- R1: After reset, all control fields, both counters and both compare values are 0, and both irq0 and irq1 are low.
- R2: The control byte layout is: bit7 match flag, bit6 flag-clear, bit5 interrupt enable, bit4 unused, bits3:1 tick source, bit0 start. On read, bit6 and bit4 return 0. Writes to bit7 and bit4 have no effect.
- R3: While start is 1, the counter increments by one on each cycle in which tickIn[source] is high. Strobes on other tickIn bits do not move it, and source code 7 on timer 0 never counts. A read of address 1 or 3 returns that counter's value on rdData, with rdValid high, one cycle after rdEn.
- R4: Writing start=1 while start is 0 clears the counter to 0. Writing start=0 stops the counter, which then holds its value.
- R5: A tick that brings a counter to its compare value sets that timer's flag at the same clock edge as the counter update.
- R6: Writing 1 to bit6 clears the flag. Writing 0 to bit6 leaves the flag unchanged. If a match and a clear fall in the same cycle, the match wins.
- R7: irqN is high exactly while flagN and enableN are both 1.
- R8: After a match the counter keeps counting. It wraps from 8'hFF to 8'h00 and matches again 256 ticks later.
- R9: With source code 7 written to control 1, the pair counts as one 16-bit counter. The low byte (data 0) carries into the high byte (data 1) when it rolls over from 8'hFF. Timer 0's source and start govern the pair: starting timer 0 clears both bytes, stopping it freezes both, and timer 1's start bit has no effect.
- R10: In 16-bit mode, flag 0 sets when the 16-bit count steps onto {compare 1, compare 0}. Flag 1 is never set in this mode, and irq1 stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 ctl0, 1 data0, 2 ctl1, 3 data1) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid with rdValid |
| rdValid | output | 1 | High one cycle after rdEn |
| tickIn | input | 7 | Prescaled single-cycle count strobes |
| irq0 | output | 1 | Timer 0 (or 16-bit pair) interrupt request |
| irq1 | output | 1 | Timer 1 interrupt request |

## Verification
A tick strobe updates the counter and the match flag at the same edge, so the interrupt lines can be seen on the next falling edge. A write takes effect at the edge that ends the write cycle. A read result comes back exactly one cycle after rdEn and is paired with its expected value through a queue that the driver fills and a monitor drains whenever rdValid is high. The bench gives each tick its own pulse, separated by an idle cycle. It samples only on falling edges, so every value it checks has already settled.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CNT_W    = 8;
  localparam int TICK_N   = 7;
  localparam int SEL_W    = $clog2(TICK_N + 1);
  localparam int TIMERS   = 2;
  localparam int WIDE_W   = CNT_W * TIMERS;
  localparam logic [SEL_W-1:0] SEL_CASCADE = '1;

  // control-register bit positions
  localparam int B_FLAG  = 7;
  localparam int B_CLR   = 6;
  localparam int B_IEN   = 5;
  localparam int B_SELHI = 3;
  localparam int B_SELLO = 1;
  localparam int B_START = 0;

  typedef enum logic [1:0] {
    A_CTL0  = 2'd0,
    A_DATA0 = 2'd1,
    A_CTL1  = 2'd2,
    A_DATA1 = 2'd3
  } regAddr_t;

  typedef struct packed {
    logic             clr0;
    logic             clr1;
    logic             run0;
    logic             run1;
    logic             cascade;
    logic [SEL_W-1:0] sel0;
    logic [SEL_W-1:0] sel1;
    logic [CNT_W-1:0] cmp0;
    logic [CNT_W-1:0] cmp1;
  } ctlToDp_t;
endpackage

// File: rtl/dctLane.sv
module dctLane
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dctDatapath.sv
module dctDatapath
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlToDp_t          ctl,
  input  logic [TICK_N-1:0] tickIn,
  output logic [CNT_W-1:0]  cnt0,
  output logic [CNT_W-1:0]  cnt1,
  output logic              hit0,
  output logic              hit1
);
  localparam int PAD_N = 1 << SEL_W;

  logic [PAD_N-1:0]  tickPad;
  logic [TIMERS-1:0] tickSel;
  logic [TIMERS-1:0] laneStep;
  logic [TIMERS-1:0] laneClr;
  logic [CNT_W-1:0]  laneCnt [TIMERS];
  logic [SEL_W-1:0]  selArr  [TIMERS];
  logic              carry;
  logic [WIDE_W-1:0] wideNext;

  // unused source codes read as a permanently low strobe
  assign tickPad   = {{(PAD_N-TICK_N){1'b0}}, tickIn};
  assign selArr[0] = ctl.sel0;
  assign selArr[1] = ctl.sel1;

  genvar gi;
  generate
    for (gi = 0; gi < TIMERS; gi++) begin : g_lane
      assign tickSel[gi] = tickPad[selArr[gi]];
      dctLane u_lane (
        .clk  (clk),
        .rstN (rstN),
        .clr  (laneClr[gi]),
        .step (laneStep[gi]),
        .cnt  (laneCnt[gi])
      );
    end
  endgenerate

  assign cnt0 = laneCnt[0];
  assign cnt1 = laneCnt[1];

  always_comb begin
    laneStep[0] = ctl.run0 & tickSel[0];
    carry       = laneStep[0] & (cnt0 == {CNT_W{1'b1}});
    laneClr[0]  = ctl.clr0;
    if (ctl.cascade) begin
      laneStep[1] = carry;
      laneClr[1]  = ctl.clr0;
    end else begin
      laneStep[1] = ctl.run1 & tickSel[1];
      laneClr[1]  = ctl.clr1;
    end
  end

  assign wideNext = {cnt1, cnt0} + 1'b1;

  always_comb begin
    if (ctl.cascade) begin
      hit0 = laneStep[0] & ~laneClr[0] & (wideNext == {ctl.cmp1, ctl.cmp0});
      hit1 = 1'b0;
    end else begin
      hit0 = laneStep[0] & ~laneClr[0] & ((cnt0 + 1'b1) == ctl.cmp0);
      hit1 = laneStep[1] & ~laneClr[1] & ((cnt1 + 1'b1) == ctl.cmp1);
    end
  end
endmodule

// File: rtl/dctControl.sv
module dctControl
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  input  logic             hit0,
  input  logic             hit1,
  output ctlToDp_t         ctl,
  output logic [CNT_W-1:0] rdData,
  output logic             rdValid,
  output logic             flag0,
  output logic             flag1,
  output logic             irq0,
  output logic             irq1
);
  logic             ien0, ien1, run0, run1;
  logic [SEL_W-1:0] sel0, sel1;
  logic [CNT_W-1:0] cmp0, cmp1;
  logic             wrCtl0, wrCtl1, wrDat0, wrDat1;
  logic             cascade;
  logic [SEL_W-1:0] newSel;
  logic [CNT_W-1:0] ctlByte0, ctlByte1, rdNext;

  assign wrCtl0  = wrEn & (regAddr_t'(addr) == A_CTL0);
  assign wrDat0  = wrEn & (regAddr_t'(addr) == A_DATA0);
  assign wrCtl1  = wrEn & (regAddr_t'(addr) == A_CTL1);
  assign wrDat1  = wrEn & (regAddr_t'(addr) == A_DATA1);
  assign newSel  = wrData[B_SELHI:B_SELLO];
  assign cascade = (sel1 == SEL_CASCADE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ien0 <= 1'b0; sel0 <= '0; run0 <= 1'b0;
      ien1 <= 1'b0; sel1 <= '0; run1 <= 1'b0;
      cmp0 <= '0;   cmp1 <= '0;
    end else begin
      if (wrCtl0) begin
        ien0 <= wrData[B_IEN];
        sel0 <= newSel;
        run0 <= wrData[B_START];
      end
      if (wrCtl1) begin
        ien1 <= wrData[B_IEN];
        sel1 <= newSel;
        run1 <= wrData[B_START];
      end
      if (wrDat0) cmp0 <= wrData;
      if (wrDat1) cmp1 <= wrData;
    end
  end

  // match has priority over a software clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag0 <= 1'b0;
      flag1 <= 1'b0;
    end else begin
      if (hit0)                        flag0 <= 1'b1;
      else if (wrCtl0 & wrData[B_CLR]) flag0 <= 1'b0;
      if (hit1)                        flag1 <= 1'b1;
      else if (wrCtl1 & wrData[B_CLR]) flag1 <= 1'b0;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.clr0    = wrCtl0 & wrData[B_START] & ~run0;
    ctl.clr1    = wrCtl1 & wrData[B_START] & ~run1 & (newSel != SEL_CASCADE);
    ctl.run0    = run0;
    ctl.run1    = run1;
    ctl.cascade = cascade;
    ctl.sel0    = sel0;
    ctl.sel1    = sel1;
    ctl.cmp0    = cmp0;
    ctl.cmp1    = cmp1;
  end

  assign irq0 = flag0 & ien0;
  assign irq1 = flag1 & ien1 & ~cascade;

  assign ctlByte0 = {flag0, 1'b0, ien0, 1'b0, sel0, run0};
  assign ctlByte1 = {flag1, 1'b0, ien1, 1'b0, sel1, run1};

  always_comb begin
    unique case (regAddr_t'(addr))
      A_CTL0:  rdNext = ctlByte0;
      A_DATA0: rdNext = cnt0;
      A_CTL1:  rdNext = ctlByte1;
      default: rdNext = cnt1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/dualCmpTimer.sv
module dualCmpTimer
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              rdValid,
  input  logic [6:0]        tickIn,
  output logic              irq0,
  output logic              irq1
);
  ctlToDp_t         ctl;
  logic [CNT_W-1:0] cnt0, cnt1;
  logic             hit0, hit1;
  logic             flag0, flag1;

  dctControl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cnt0(cnt0), .cnt1(cnt1), .hit0(hit0), .hit1(hit1),
    .ctl(ctl), .rdData(rdData), .rdValid(rdValid),
    .flag0(flag0), .flag1(flag1), .irq0(irq0), .irq1(irq1)
  );

  dctDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tickIn(tickIn),
    .cnt0(cnt0), .cnt1(cnt1), .hit0(hit0), .hit1(hit1)
  );
endmodule

// File: rtl/dctChecker.sv
module dctChecker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic       run0,
  input logic       cascade,
  input logic [7:0] cnt0,
  input logic [7:0] cnt1,
  input logic       hit0,
  input logic       flag0,
  input logic       irq0
);
  logic wrCtl0;
  assign wrCtl0 = wrEn && (addr == 2'd0);

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run0 && !wrCtl0) |=> (cnt0 == $past(cnt0)));

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl0 && wrData[0] && !run0) |=> (cnt0 == 8'd0));

  // R5
  match_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit0 |=> flag0);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl0 && wrData[6] && !hit0) |=> !flag0);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq0 |-> flag0);

  // R9
  cascade_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cascade && !run0 && !wrCtl0) |=> $stable(cnt1));
endmodule

bind dualCmpTimer dctChecker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .run0(ctl.run0), .cascade(ctl.cascade), .cnt0(cnt0), .cnt1(cnt1),
  .hit0(hit0), .flag0(flag0), .irq0(irq0)
);

// File: tb/dualCmpTimer_tb.sv
module dualCmpTimer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [6:0] tickIn = '0;
  logic [7:0] rdData;
  logic       rdValid;
  logic       irq0, irq1;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  dualCmpTimer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .tickIn(tickIn), .irq0(irq0), .irq1(irq1)
  );

  // monitor: pair every returned read with the oldest expectation
  always @(negedge clk) begin
    if (rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: actual %h expected none", rdData);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string      t = tagQ.pop_front();
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rdData, e);
        end
      end
    end
  end

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, input logic [7:0] e, input string t);
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 7'd1 << idx;
      @(negedge clk); tickIn = '0;
    end
  endtask

  task automatic checkIrq(input logic e0, input logic e1, input string t);
    @(negedge clk);
    checks++;
    if (irq0 !== e0 || irq1 !== e1) begin
      errors++;
      $display("FAIL %s: actual irq %b%b expected %b%b", t, irq0, irq1, e0, e1);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkIrq(1'b0, 1'b0, "R1 irq after reset");
    readReg(2'd0, 8'h00, "R1 ctl0 reset");
    readReg(2'd1, 8'h00, "R1 cnt0 reset");
    readReg(2'd2, 8'h00, "R1 ctl1 reset");
    readReg(2'd3, 8'h00, "R1 cnt1 reset");

    // R3 counting on selected source only
    writeReg(2'd1, 8'd5);
    writeReg(2'd0, 8'h25);            // ien, source 2, start
    pulse(2, 3);
    readReg(2'd1, 8'd3, "R3 count on source 2");
    pulse(1, 2);
    pulse(6, 1);
    readReg(2'd1, 8'd3, "R3 other sources ignored");
    checkIrq(1'b0, 1'b0, "R5 no match yet");
    pulse(2, 2);
    checkIrq(1'b1, 1'b0, "R5 R7 match raises irq0");
    readReg(2'd0, 8'hA5, "R2 R5 ctl0 flag set, bit6 and bit4 read 0");

    // R6 flag clear behaviour
    writeReg(2'd0, 8'h25);
    readReg(2'd0, 8'hA5, "R6 clear bit 0 keeps flag");
    writeReg(2'd0, 8'h65);
    checkIrq(1'b0, 1'b0, "R6 R7 clear drops irq0");
    readReg(2'd0, 8'h25, "R6 flag cleared");
    readReg(2'd1, 8'd5, "R4 start already 1 does not clear");
    writeReg(2'd0, 8'hB5);             // bit7 and bit4 written
    readReg(2'd0, 8'h25, "R2 bit7 and bit4 writes ignored");

    // R4 stop and restart
    writeReg(2'd0, 8'h24);
    pulse(2, 3);
    readReg(2'd1, 8'd5, "R4 stopped counter holds");
    writeReg(2'd0, 8'h25);
    readReg(2'd1, 8'd0, "R4 restart clears counter");

    // R8 wrap and match again
    writeReg(2'd1, 8'd2);
    pulse(2, 2);
    checkIrq(1'b1, 1'b0, "R5 match at 2");
    writeReg(2'd0, 8'h65);
    pulse(2, 255);
    checkIrq(1'b0, 1'b0, "R8 no match before full wrap");
    readReg(2'd1, 8'd1, "R8 counter wrapped past FF");
    pulse(2, 1);
    checkIrq(1'b1, 1'b0, "R8 match again after wrap");

    // R7 enable gating
    writeReg(2'd0, 8'h45);             // clear flag, ien off
    pulse(2, 256);
    checkIrq(1'b0, 1'b0, "R7 irq0 gated by enable");
    readReg(2'd0, 8'h85, "R7 flag set while disabled");

    // timer 1 in 8-bit mode
    writeReg(2'd3, 8'd3);
    writeReg(2'd2, 8'h21);             // ien1, source 0, start
    pulse(0, 3);
    checkIrq(1'b0, 1'b1, "R5 R7 timer1 match raises irq1");
    readReg(2'd3, 8'd3, "R3 timer1 count");
    readReg(2'd1, 8'd2, "R3 timer0 unaffected by source 0");

    // R9 R10 cascade
    writeReg(2'd0, 8'h64);             // stop, clear flag, ien
    writeReg(2'd1, 8'h02);
    writeReg(2'd3, 8'h01);
    writeReg(2'd2, 8'h6E);             // clear flag1, ien1, cascade code
    writeReg(2'd0, 8'h25);             // start pair
    readReg(2'd3, 8'd0, "R9 start clears high byte");
    pulse(2, 256);
    readReg(2'd1, 8'd0, "R9 low byte rolled over");
    readReg(2'd3, 8'd1, "R9 carry into high byte");
    pulse(2, 1);
    checkIrq(1'b0, 1'b0, "R10 no match at 0x0101");
    pulse(2, 1);
    checkIrq(1'b1, 1'b0, "R10 16-bit match on irq0 only");
    readReg(2'd2, 8'h2E, "R10 flag1 stays clear");
    writeReg(2'd2, 8'h2F);             // timer1 start bit, inert
    readReg(2'd1, 8'd2, "R9 timer1 start no effect low");
    readReg(2'd3, 8'd1, "R9 timer1 start no effect high");
    writeReg(2'd0, 8'h24);
    pulse(2, 3);
    readReg(2'd1, 8'd2, "R9 stop freezes low byte");
    readReg(2'd3, 8'd1, "R9 stop freezes high byte");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending reads expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule